// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Controller

This block is the digital half of an 8-bit successive-approximation converter that talks to a host over a three-wire serial link. The link has an active-low frame select, a serial clock, a data input and a data output with a separate output-enable. A busy flag is also provided. The block also drives the analog side. It supplies the trial code that the DAC ladder should produce and the multiplexer selects for the positive and negative inputs. In return it receives a single comparator decision bit.

A frame opens when frame select goes low. The controller hunts for the first 1 on the data input, which is the start bit. It then takes in a channel-select word and waits half a serial clock for the multiplexer to settle. It then drives a dummy zero and runs eight comparison steps. Each decided bit appears on the data output at the falling serial edge that decides it. After the last step, the word is replayed least significant bit first, and the final bit of the first pass is shared. The line is then held low until frame select rises.

The serial clock and the control inputs are synchronous to the system clock `clk`. Each serial clock level lasts at least two system clock cycles. Serial edges are found by comparing `sclk` with its value one system cycle earlier.

Top module: `sar_serial_ctrl`

## Requirements
- R1: While `cs_n` is high, and in reset, `dout_oe`, `busy`, `dout` and `trial_code` are 0 and the mux outputs return to 0. Raising `cs_n` at any point abandons the frame, so the next frame behaves as if it were the first.
- R2: `din` is sampled only at rising `sclk` edges. Zeros before the first 1 are ignored and do not start anything. The first 1 is the start bit.
- R3: The ADDR_W (0, 2, 3 or 4) bits after the start bit are the channel word, sent most significant bit first. Its first bit set to 1 selects single-ended mode, with `mux_neg_com`=1. Set to 0 it selects differential mode, with `mux_neg` = channel index XOR 1. The remaining ADDR_W-1 bits are the channel index and drive `mux_pos`. With ADDR_W=0 there is no channel word, and the selection is fixed at positive 0, negative 1, differential.
- R4: At the first falling `sclk` edge after the last channel-word bit (or after the start bit when ADDR_W=0), `busy` and `dout_oe` go to 1 and `dout` drives 0.
- R5: While `dout_oe` is 1, and until `cs_n` rises after a conversion, `din` has no effect on the result or the mux selects.
- R6: During the conversion, `trial_code` equals the bits decided so far, with a 1 at the bit under test and zeros below it. It is 0x80 right after the settling edge.
- R7: Each of the next 8 falling `sclk` edges captures `cmp_in` as the next result bit, from MSB to LSB. The same edge puts that bit on `dout`.
- R8: `busy` stays 1 through the 8th decision and falls at the following rising `sclk` edge, while `dout` keeps driving the LSB.
- R9: The next 7 falling edges present result bits 1 to 7 in turn. The LSB is not sent a second time.
- R10: The falling edge after bit 7 of the second pass drives `dout` to 0, and it stays 0 with `dout_oe` at 1 until `cs_n` rises.
- R11: When the positive input lies below the negative input, every comparator decision is 0 and both passes send 0x00.
- R12: An input difference of full scale yields 0xFF in both passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, synchronous to clk |
| din | input | 1 | Serial data in (start bit and channel word) |
| dout | output | 1 | Serial data out value |
| dout_oe | output | 1 | Output enable for dout (0 = high impedance) |
| busy | output | 1 | Conversion in progress |
| trial_code | output | DATA_W | Code for the DAC ladder at the current step |
| cmp_in | input | 1 | Comparator decision (1 = input at or above trial code) |
| mux_pos | output | CH_W | Positive input channel index |
| mux_neg | output | CH_W | Negative input channel index (differential mode) |
| mux_neg_com | output | 1 | Negative input taken from the common terminal |

## Verification
The bench sends start bits after runs of 0 to 9 leading zeros. A design that treated a leading zero as framing would select the wrong channel and return a wrong code. It aborts frames in mid-address and mid-conversion. A controller that kept stale shift or result state would then mis-decode the next frame. Some frames hold `din` high, or tie it to `dout`, while the output is driven. A design that listened there would restart or corrupt its selects. It also checks the exact edge of the settling zero, the busy drop after the eighth decision and the shared LSB. A design off by one half clock there would show an extra or missing bit in the replay. It also covers negative differences, which must give 0x00, and full scale, which must give 0xFF.

// File: rtl/sar_serial_pkg.sv
package sar_serial_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_HUNT   = 4'd1,
    ST_ADDR   = 4'd2,
    ST_SETTLE = 4'd3,
    ST_CONV   = 4'd4,
    ST_LAST   = 4'd5,
    ST_TAIL   = 4'd6,
    ST_DRAIN  = 4'd7,
    ST_ZERO   = 4'd8
  } frame_state_e;

endpackage

// File: rtl/sar_frame_seq.sv
module sar_frame_seq
  import sar_serial_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               din,
  output frame_state_e       state_o,
  output logic [CNT_W-1:0]   step_o,
  output logic               fall_o,
  output logic               addr_shift_o,
  output logic               busy_o,
  output logic               drive_o
);

  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'((ADDR_W > 0) ? ADDR_W - 1 : 0);
  localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] TAIL_LAST = CNT_W'(DATA_W - 2);

  logic             sclk_q;
  logic             rise, fall;
  frame_state_e     state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (cs_n) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_IDLE: state_d = ST_HUNT;
        ST_HUNT: begin
          if (rise && din) begin
            cnt_d   = '0;
            state_d = (ADDR_W == 0) ? ST_SETTLE : ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (rise) begin
            if (cnt_q == ADDR_LAST) begin
              state_d = ST_SETTLE;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_SETTLE: begin
          if (fall) begin
            state_d = ST_CONV;
            cnt_d   = '0;
          end
        end
        ST_CONV: begin
          if (fall) begin
            if (cnt_q == STEP_LAST) begin
              state_d = ST_LAST;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_LAST: begin
          if (rise) begin
            state_d = ST_TAIL;
            cnt_d   = '0;
          end
        end
        ST_TAIL: begin
          if (fall) begin
            if (cnt_q == TAIL_LAST) begin
              state_d = ST_DRAIN;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_DRAIN: if (fall) state_d = ST_ZERO;
        ST_ZERO:  state_d = ST_ZERO;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o      = state_q;
  assign step_o       = cnt_q;
  assign fall_o       = fall;
  assign addr_shift_o = (state_q == ST_ADDR) && rise;
  assign busy_o       = (state_q == ST_CONV) || (state_q == ST_LAST);
  assign drive_o      = (state_q == ST_CONV) || (state_q == ST_LAST) ||
                        (state_q == ST_TAIL) || (state_q == ST_DRAIN) ||
                        (state_q == ST_ZERO);

  // R1: a high frame select always returns the sequencer to idle
  a_r1_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (state_q == ST_IDLE));

  // R2: no frame progresses past the hunt without a 1 on din at a rise
  a_r2_start_needs_one: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HUNT && !(rise && din)) |=> (state_q == ST_HUNT || state_q == ST_IDLE));

endmodule

// File: rtl/sar_chan_decode.sv
module sar_chan_decode #(
  parameter int ADDR_W = 4,
  parameter int CH_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            shift_en,
  input  logic            load_en,
  input  logic            din,
  input  logic            drive_on,
  output logic [CH_W-1:0] pos_o,
  output logic [CH_W-1:0] neg_o,
  output logic            neg_com_o
);

  generate
    if (ADDR_W == 0) begin : g_fixed
      assign pos_o     = '0;
      assign neg_o     = CH_W'(1);
      assign neg_com_o = 1'b0;
    end else begin : g_addr
      logic [ADDR_W-1:0] sr_q, sr_d;
      logic [CH_W-1:0]   pos_q, pos_d, neg_q, neg_d;
      logic              com_q, com_d;
      logic [CH_W-1:0]   ch;

      assign ch = sr_q[ADDR_W-2:0];

      always_comb begin
        sr_d  = sr_q;
        pos_d = pos_q;
        neg_d = neg_q;
        com_d = com_q;
        if (clear) begin
          sr_d  = '0;
          pos_d = '0;
          neg_d = '0;
          com_d = 1'b0;
        end else begin
          if (shift_en) sr_d = {sr_q[ADDR_W-2:0], din};
          if (load_en) begin
            pos_d = ch;
            com_d = sr_q[ADDR_W-1];
            neg_d = sr_q[ADDR_W-1] ? '0 : {ch[CH_W-1:1], ~ch[0]};
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr_q  <= '0;
          pos_q <= '0;
          neg_q <= '0;
          com_q <= 1'b0;
        end else begin
          sr_q  <= sr_d;
          pos_q <= pos_d;
          neg_q <= neg_d;
          com_q <= com_d;
        end
      end

      assign pos_o     = pos_q;
      assign neg_o     = neg_q;
      assign neg_com_o = com_q;

      // R5: the channel word cannot move while the output is driven
      a_r5_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        drive_on |=> $stable(sr_q));

      // R3: a differential pair always has two members of one adjacent pair
      a_r3_pair_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_on && !com_q) |-> ((pos_q ^ neg_q) == CH_W'(1)));
    end
  endgenerate

endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              active,
  input  logic              decide,
  input  logic [CNT_W-1:0]  step,
  input  logic              cmp_in,
  output logic [DATA_W-1:0] trial_o,
  output logic [DATA_W-1:0] result_o
);

  localparam logic [CNT_W-1:0] STEP_TOP = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bitpos;
  logic [DATA_W-1:0] onebit;
  logic [DATA_W-1:0] res_q, res_d;

  assign bitpos = STEP_TOP - step;
  assign onebit = DATA_W'(1) << bitpos;

  always_comb begin
    res_d = res_q;
    if (clear) begin
      res_d = '0;
    end else if (decide) begin
      res_d = (res_q & ~onebit) | (cmp_in ? onebit : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign trial_o  = active ? (res_q | onebit) : '0;
  assign result_o = res_q;

  // R6: bits below the one under test are still undecided zeros
  a_r6_low_undecided: assert property (@(posedge clk) disable iff (!rst_n)
    decide |-> ((res_q & (onebit - 1'b1)) == '0));

  // R7: the captured bit equals the comparator decision
  a_r7_bit_captured: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !clear) |=> (((res_q >> $past(bitpos)) & DATA_W'(1)) == DATA_W'($past(cmp_in))));

endmodule

// File: rtl/sar_serial_out.sv
module sar_serial_out
  import sar_serial_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fall,
  input  frame_state_e      state,
  input  logic [CNT_W-1:0]  step,
  input  logic              cmp_in,
  input  logic [DATA_W-1:0] result,
  output logic              dout_o
);

  logic             dout_q, dout_d;
  logic [CNT_W-1:0] tail_idx;

  assign tail_idx = step + 1'b1;

  always_comb begin
    dout_d = dout_q;
    if (clear) begin
      dout_d = 1'b0;
    end else if (fall) begin
      case (state)
        ST_SETTLE: dout_d = 1'b0;
        ST_CONV:   dout_d = cmp_in;
        ST_TAIL:   dout_d = result[tail_idx];
        ST_DRAIN:  dout_d = 1'b0;
        default:   dout_d = dout_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= 1'b0;
    else        dout_q <= dout_d;
  end

  assign dout_o = dout_q;

  // R9: while waiting for the replay, the line carries the stored LSB
  a_r9_lsb_shared: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LAST) |-> (dout_q == result[0]));

  // R10: after the replay the line is held low
  a_r10_tail_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ZERO) |-> !dout_q);

endmodule

// File: rtl/sar_serial_ctrl.sv
module sar_serial_ctrl
  import sar_serial_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int CH_W  = (ADDR_W > 1) ? ADDR_W - 1 : 1,
  localparam int CNT_W = $clog2((DATA_W > ADDR_W) ? DATA_W : ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic              busy,
  output logic [DATA_W-1:0] trial_code,
  input  logic              cmp_in,
  output logic [CH_W-1:0]   mux_pos,
  output logic [CH_W-1:0]   mux_neg,
  output logic              mux_neg_com
);

  frame_state_e      state;
  logic [CNT_W-1:0]  step;
  logic              fall;
  logic              addr_shift;
  logic              clear;
  logic              conv_active;
  logic              decide;
  logic [DATA_W-1:0] result;
  logic              dout_raw;

  sar_frame_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .sclk         (sclk),
    .din          (din),
    .state_o      (state),
    .step_o       (step),
    .fall_o       (fall),
    .addr_shift_o (addr_shift),
    .busy_o       (busy),
    .drive_o      (dout_oe)
  );

  assign clear       = (state == ST_IDLE);
  assign conv_active = (state == ST_CONV);
  assign decide      = conv_active && fall;

  sar_chan_decode #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .shift_en  (addr_shift),
    .load_en   (state == ST_SETTLE),
    .din       (din),
    .drive_on  (dout_oe),
    .pos_o     (mux_pos),
    .neg_o     (mux_neg),
    .neg_com_o (mux_neg_com)
  );

  sar_core #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .active   (conv_active),
    .decide   (decide),
    .step     (step),
    .cmp_in   (cmp_in),
    .trial_o  (trial_code),
    .result_o (result)
  );

  sar_serial_out #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .fall   (fall),
    .state  (state),
    .step   (step),
    .cmp_in (cmp_in),
    .result (result),
    .dout_o (dout_raw)
  );

  assign dout = dout_oe & dout_raw;

  // R4: busy rises together with the driven leading zero
  a_r4_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (dout_oe && !dout));

  // R8: a normal end of conversion leaves the line driven
  a_r8_busy_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(cs_n)) |-> dout_oe);

  // R1: one cycle after frame select rises, the port is quiet
  a_r1_port_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!dout_oe && !busy && trial_code == '0));

  // R7: a conversion in progress always drives the line
  a_r7_busy_drives: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> dout_oe);

endmodule

// File: tb/tb_sar_serial_ctrl.sv
module tb_sar_serial_ctrl;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int CH_W   = 3;
  localparam logic [7:0] CHV [8] = '{8'd200, 8'd55, 8'd0, 8'd255,
                                     8'd128, 8'd127, 8'd1, 8'd90};
  localparam int COM_V = 30;
  // {leading zeros, channel word {single-ended, index[2:0]}}
  localparam logic [7:0] VEC [12] = '{8'h08, 8'h30, 8'h11, 8'h2B,
                                      8'h03, 8'h52, 8'h14, 8'h05,
                                      8'h9E, 8'h4F, 8'h26, 8'h07};

  logic              clk = 1'b0;
  logic              rst_n, cs_n, sclk, din_drv, tie;
  logic              din, dout, dout_oe, busy, cmp_in, mux_neg_com;
  logic [DATA_W-1:0] trial_code;
  logic [CH_W-1:0]   mux_pos, mux_neg;
  int                checks = 0;
  int                failures = 0;
  bit                done = 1'b0;

  always #4 clk = ~clk;

  assign din = tie ? dout : din_drv;

  always_comb begin
    int vp, vn;
    vp = int'(CHV[mux_pos]);
    vn = mux_neg_com ? COM_V : int'(CHV[mux_neg]);
    cmp_in = ((vp - vn) >= int'(trial_code));
  end

  sar_serial_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .busy(busy), .trial_code(trial_code),
    .cmp_in(cmp_in), .mux_pos(mux_pos), .mux_neg(mux_neg),
    .mux_neg_com(mux_neg_com)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic half(input logic lvl);
    sclk = lvl;
    tick(4);
  endtask

  function automatic int exp_code(input logic [3:0] w);
    int vp, vn;
    vp = int'(CHV[w[2:0]]);
    vn = w[3] ? COM_V : int'(CHV[w[2:0] ^ 3'd1]);
    return (vp < vn) ? 0 : vp - vn;
  endfunction

  // mode 0: din low while driven, 1: din held high, 2: din tied to dout
  task automatic run_frame(input logic [3:0] nlead, input logic [3:0] w, input int mode);
    int exp_v;
    logic [7:0] e;
    exp_v = exp_code(w);
    e = 8'(exp_v);
    cs_n = 1'b0; din_drv = 1'b0; tie = 1'b0;
    tick(4);
    for (int i = 0; i < int'(nlead); i++) begin
      din_drv = 1'b0; half(1'b1); half(1'b0);
    end
    chk("R2 no start on leading zeros busy", int'(busy), 0);
    chk("R2 no start on leading zeros oe", int'(dout_oe), 0);
    din_drv = 1'b1; half(1'b1); half(1'b0);
    for (int i = 3; i >= 0; i--) begin
      din_drv = w[i]; half(1'b1);
      if (i == 0) begin
        chk("R4 busy low before settle fall", int'(busy), 0);
        if (mode == 1) din_drv = 1'b1;
        if (mode == 2) tie = 1'b1;
      end
      half(1'b0);
    end
    chk("R4 busy at settle", int'(busy), 1);
    chk("R4 lead zero", int'(dout), 0);
    chk("R4 oe at settle", int'(dout_oe), 1);
    chk("R3 mux_pos", int'(mux_pos), int'(w[2:0]));
    chk("R3 mux_neg_com", int'(mux_neg_com), int'(w[3]));
    if (!w[3]) chk("R3 mux_neg pair", int'(mux_neg), int'(w[2:0] ^ 3'd1));
    chk("R6 first trial", int'(trial_code), 8'h80);
    for (int k = 0; k < 8; k++) begin
      half(1'b1);
      chk("R8 busy during steps", int'(busy), 1);
      half(1'b0);
      chk("R7 decided bit msb first", int'(dout), int'(e[7-k]));
      if (k < 7)
        chk("R6 trial code", int'(trial_code),
            int'((e & (8'hFF << (7 - k))) | (8'h01 << (6 - k))));
    end
    chk("R8 busy held after last step", int'(busy), 1);
    half(1'b1);
    chk("R8 busy drops", int'(busy), 0);
    chk("R8 lsb still driven", int'(dout), int'(e[0]));
    chk("R8 oe in gap", int'(dout_oe), 1);
    for (int j = 1; j < 8; j++) begin
      half(1'b0);
      chk("R9 replay bit lsb first", int'(dout), int'(e[j]));
      half(1'b1);
    end
    half(1'b0);
    chk("R10 line low after replay", int'(dout), 0);
    chk("R10 oe after replay", int'(dout_oe), 1);
    half(1'b1); half(1'b0); half(1'b1); half(1'b0);
    chk("R10 line stays low", int'(dout), 0);
    if (exp_v == 0)   chk("R11 negative gives zero", int'(e), 0);
    if (exp_v == 255) chk("R12 full scale", int'(e), 255);
    if (mode != 0) chk("R5 din ignored while driven", int'(e), exp_v);
    cs_n = 1'b1; tie = 1'b0; din_drv = 1'b0;
    tick(2);
    chk("R1 oe after cs high", int'(dout_oe), 0);
    chk("R1 busy after cs high", int'(busy), 0);
    tick(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din_drv = 1'b0; tie = 1'b0;
    tick(3);
    chk("R1 reset oe", int'(dout_oe), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset trial", int'(trial_code), 0);
    chk("R1 reset dout", int'(dout), 0);
    rst_n = 1'b1;
    tick(4);

    for (int v = 0; v < 12; v++)
      run_frame(VEC[v][7:4], VEC[v][3:0], v % 3);

    // R1 abort in the middle of the channel word, then a clean frame
    cs_n = 1'b0; tick(4);
    din_drv = 1'b1; half(1'b1); half(1'b0);
    din_drv = 1'b1; half(1'b1); half(1'b0);
    din_drv = 1'b1; half(1'b1); half(1'b0);
    cs_n = 1'b1; tick(2);
    chk("R1 abort in address oe", int'(dout_oe), 0);
    tick(4);
    run_frame(4'd1, 4'h0, 0);

    // R1 abort in the middle of the conversion, then a clean frame
    cs_n = 1'b0; tick(4);
    din_drv = 1'b1; half(1'b1); half(1'b0);
    for (int i = 3; i >= 0; i--) begin
      din_drv = 1'(4'hB >> i); half(1'b1); half(1'b0);
    end
    half(1'b1); half(1'b0); half(1'b1); half(1'b0);
    chk("R1 busy before abort", int'(busy), 1);
    cs_n = 1'b1; tick(2);
    chk("R1 abort busy", int'(busy), 0);
    chk("R1 abort oe", int'(dout_oe), 0);
    chk("R1 abort trial", int'(trial_code), 0);
    chk("R1 abort mux_pos", int'(mux_pos), 0);
    chk("R1 abort mux_neg_com", int'(mux_neg_com), 0);
    tick(4);
    run_frame(4'd0, 4'h7, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule